// File: doc/BRIEF.md
# Cascaded Backplane Phase Synchronizer

This block produces the backplane phase sequence for one display driver that sits in a chain of identical drivers. Each backplane period, called a slot, lasts a fixed number of clocks. The driver steps through its active backplanes in turn, and one pass over all of them is a frame. A multiplex mode input selects how many backplanes are active, from one to four.

All drivers in the chain share one wired, active-low sync line with a pull-up. Each driver pulls the line low while it is in its own last active slot, and watches the line at all other times. When the line falls and the fall was not caused by this driver, the driver moves its phase onto the phase of the device that pulled. The next slot boundary then wraps it to backplane 0 together with the rest of the chain. Every instance leaves reset in the same phase, so no sync event is needed after power-up.

The sampled line passes through a two-flop synchronizer. A fall that this driver caused is masked by delaying its own pull-down request by the same number of stages.

Top module: `bp_phase_sync`

## Requirements
- R1: In the first clock after reset is released, `bp_idx` is 0, `slot_stb` is 1 and, with four backplanes selected, `sync_pull` is 0.
- R2: `slot_stb` is high for exactly one clock, the first clock of each slot. Without a realignment, slots are SLOT_CYCLES clocks long.
- R3: `mux_mode` value m selects m+1 active backplanes (0 = one, 3 = four). `bp_idx` counts 0, 1, … up to m and then returns to 0. It changes only at a slot strobe or right after a realignment.
- R4: `sync_pull` is 1 from the first clock of the last active slot through the next-to-last clock of that slot, and 0 in every other clock.
- R5: With `mux_mode` = 0, `bp_idx` stays 0 and every slot is a whole frame. Per R4, the line is pulled for SLOT_CYCLES-1 clocks of each slot and released for one clock.
- R6: Suppose `sync_n` falls from 1 to 0 during clock k while this block's own pull was 0 in clock k. Then from clock k+3 to clock k+SLOT_CYCLES-1, `bp_idx` holds the last active index and `sync_pull` follows R4. In clock k+SLOT_CYCLES, `slot_stb` is 1 and `bp_idx` is 0.
- R7: A fall of `sync_n` caused by this block's own `sync_pull` leaves the slot and backplane sequence unchanged.
- R8: Another device pulling a line that is already held low produces no 1-to-0 transition, and it leaves the sequence unchanged.
- R9: `mux_mode` is sampled only at the boundary that starts a new frame. A change made mid-frame lets the current frame finish with the old backplane count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_mode | input | 2 | Active backplane count minus one |
| sync_n | input | 1 | Sampled level of the shared sync line, low = active |
| bp_idx | output | 2 | Index of the current backplane |
| slot_stb | output | 1 | High in the first clock of every slot |
| sync_pull | output | 1 | 1 = pull the shared line low, 0 = release it |

## Verification
The bound checker covers the cycle-level rules on every clock:
- the strobe is a single-clock pulse;
- the index holds between strobes and steps by one or returns to 0 at a strobe;
- the pull is active only in the last active slot;
- the mode changes only at a frame start;
- a realignment lands the index on the last active backplane.

Other properties can only be shown by the bench's scenarios, with a second device modelled on the wired line:
- the exact clock in which a foreign fall moves the phase;
- that the block ignores its own fall and an already-low line;
- that a mode change made mid-frame is deferred to the next frame.

// File: rtl/bpsync_pkg.sv
package bpsync_pkg;
    localparam int MAX_BP = 4;
    localparam int BP_W   = $clog2(MAX_BP);
    typedef logic [BP_W-1:0] bp_idx_t;
endpackage

// File: rtl/bpsync_edge.sv
// Synchronizes the shared line and flags a foreign released-to-active edge.
module bpsync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    input  logic own_pull,
    output logic ext_fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
        logic [STAGES-1:0] own_dly;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync    = {st_q.sync[STAGES-2:0], line_n};
        st_d.prev    = st_q.sync[STAGES-1];
        // Own request delayed to match the synchronizer depth.
        st_d.own_dly = {st_q.own_dly[STAGES-2:0], own_pull};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sync: '1, prev: 1'b1, own_dly: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ext_fall = st_q.prev & ~st_q.sync[STAGES-1] & ~st_q.own_dly[STAGES-1];
endmodule

// File: rtl/bpsync_phase.sv
// Slot position, backplane index and frame-latched mode.
module bpsync_phase
    import bpsync_pkg::*;
#(
    parameter int SLOT_CYCLES = 8,
    parameter int REALIGN_POS = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  bp_idx_t mux_mode,
    input  logic    ext_fall,
    output bp_idx_t bp_idx,
    output bp_idx_t mode_cur,
    output logic    slot_first,
    output logic    slot_final,
    output logic    in_last
);
    localparam int CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYCLES - 1);
    localparam logic [CYC_W-1:0] CYC_JUMP = CYC_W'(REALIGN_POS);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        bp_idx_t          bp;
        bp_idx_t          mode;
    } ph_st_t;

    ph_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ext_fall) begin
            // Match a device that began its last slot REALIGN_POS-1 clocks ago.
            st_d.bp  = st_q.mode;
            st_d.cyc = CYC_JUMP;
        end else if (st_q.cyc == CYC_LAST) begin
            st_d.cyc = '0;
            if (st_q.bp == st_q.mode) begin
                st_d.bp   = '0;
                st_d.mode = mux_mode;
            end else begin
                st_d.bp = st_q.bp + 1'b1;
            end
        end else begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cyc: '0, bp: '0, mode: mux_mode};
        end else begin
            st_q <= st_d;
        end
    end

    assign bp_idx     = st_q.bp;
    assign mode_cur   = st_q.mode;
    assign slot_first = (st_q.cyc == '0);
    assign slot_final = (st_q.cyc == CYC_LAST);
    assign in_last    = (st_q.bp == st_q.mode);
endmodule

// File: rtl/bp_phase_sync.sv
module bp_phase_sync
    import bpsync_pkg::*;
#(
    parameter int SLOT_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mux_mode,
    input  logic       sync_n,
    output logic [1:0] bp_idx,
    output logic       slot_stb,
    output logic       sync_pull
);
    localparam int REALIGN_POS = SYNC_STAGES + 1;

    bp_idx_t mode_cur;
    logic    realign;
    logic    slot_final;
    logic    in_last;

    bpsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n   (sync_n),
        .own_pull (sync_pull),
        .ext_fall (realign)
    );

    bpsync_phase #(
        .SLOT_CYCLES (SLOT_CYCLES),
        .REALIGN_POS (REALIGN_POS)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .mux_mode   (mux_mode),
        .ext_fall   (realign),
        .bp_idx     (bp_idx),
        .mode_cur   (mode_cur),
        .slot_first (slot_stb),
        .slot_final (slot_final),
        .in_last    (in_last)
    );

    // Pull during the last active slot, releasing in its final clock.
    always_comb begin
        sync_pull = in_last & ~slot_final;
    end
endmodule

// File: rtl/bp_phase_sync_chk.sv
module bp_phase_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bp_idx,
    input logic       slot_stb,
    input logic       sync_pull,
    input logic [1:0] mode_cur,
    input logic       realign
);
    assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb |=> !slot_stb);

    assert_bp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_stb && !$past(realign)) |-> (bp_idx == $past(bp_idx)));

    assert_bp_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && !$past(realign)) |->
            (bp_idx == 2'd0 || bp_idx == 2'($past(bp_idx) + 2'd1)));

    assert_pull_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pull |-> (bp_idx == mode_cur));

    assert_mode_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur != $past(mode_cur)) |-> (slot_stb && bp_idx == 2'd0));

    assert_realign_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (bp_idx == mode_cur && !slot_stb));
endmodule

bind bp_phase_sync bp_phase_sync_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bp_idx    (bp_idx),
    .slot_stb  (slot_stb),
    .sync_pull (sync_pull),
    .mode_cur  (mode_cur),
    .realign   (realign)
);

// File: tb/bp_phase_sync_test.sv
`timescale 1ns/1ps
module bp_phase_sync_test;
    localparam int SLOT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mux_mode = 2'd3;
    logic       ext_pull = 1'b0;
    logic       sync_n;
    logic [1:0] bp_idx;
    logic       slot_stb;
    logic       sync_pull;

    always #2.5 clk = ~clk;

    // Wired line: either device pulling drives it low.
    assign sync_n = ~(sync_pull | ext_pull);

    bp_phase_sync #(.SLOT_CYCLES(SLOT), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mux_mode  (mux_mode),
        .sync_n    (sync_n),
        .bp_idx    (bp_idx),
        .slot_stb  (slot_stb),
        .sync_pull (sync_pull)
    );

    typedef struct {
        int    bp;
        bit    stb;
        bit    pull;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc_no   = 0;
    int   cur      = 0;
    bit   done     = 1'b0;

    // Expected slot contents from R2/R4: strobe on position 0,
    // pull in the last active slot except its final position.
    task automatic push_slot(input int bp, input int last, input int c0,
                             input int n, input string tag);
        for (int i = c0; i < c0 + n; i++) begin
            exp_t e;
            e.bp   = bp;
            e.stb  = (i == 0);
            e.pull = (bp == last) && (i != SLOT - 1);
            e.tag  = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic push_frame(input int last, input string tag);
        for (int b = 0; b <= last; b++) push_slot(b, last, 0, SLOT, tag);
    endtask

    task automatic goto_cycle(input int c);
        while (cur < c) begin
            @(posedge clk);
            cur++;
        end
        #1;
    endtask

    // Monitor: compare one expected item per clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (int'(bp_idx) != e.bp || slot_stb != e.stb || sync_pull != e.pull) begin
                n_fail++;
                $display("FAIL %s cycle %0d: bp=%0d stb=%0b pull=%0b expected bp=%0d stb=%0b pull=%0b",
                         e.tag, cyc_no, bp_idx, slot_stb, sync_pull, e.bp, e.stb, e.pull);
            end
            cyc_no++;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cur   = 0;
        // Cycles 0..63: four backplanes (R1 on the very first clock)
        push_slot(0, 3, 0, 1, "R1");
        push_slot(0, 3, 1, SLOT - 1, "R3 R2 R4");
        for (int b = 1; b < 4; b++) push_slot(b, 3, 0, SLOT, "R3 R2 R4");
        push_frame(3, "R9");          // mode changed at 40, still 4 slots
        push_frame(1, "R3");          // 64..95
        push_frame(1, "R3");
        push_frame(0, "R5");          // 96..111 static
        push_frame(0, "R5");
        push_slot(0, 3, 0, SLOT, "R6");   // 112..119
        push_slot(1, 3, 0, 5, "R6");      // 120..124
        push_slot(3, 3, 3, 5, "R6");      // 125..129 after foreign fall at 122
        push_frame(3, "R7");          // 130..193 own falls ignored
        push_frame(3, "R7");
        push_frame(3, "R8");          // 194..225 foreign pull on low line
        push_frame(3, "R8");          // 226..257

        goto_cycle(40);  mux_mode = 2'd1;
        goto_cycle(90);  mux_mode = 2'd0;
        goto_cycle(108); mux_mode = 2'd3;
        goto_cycle(122); ext_pull = 1'b1;
        goto_cycle(130); ext_pull = 1'b0;
        goto_cycle(220); ext_pull = 1'b1;
        goto_cycle(224); ext_pull = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, %0d items left (expected 0)", exp_q.size());
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule